// File: doc/BRIEF.md
# Banked SPI Register Command Interface

This block is the SPI slave front end that gives a host processor access to the control registers and the packet buffer memory of a network controller. Every transaction begins with chip select going low and a command byte. The command byte holds an operation code and a register address. The bytes that follow carry write data, or they clock out read data. Raising chip select ends the transaction.

Register addresses 0x00 to 0x1A belong to one of four banks. A two-bit bank field in a control register chooses the bank, and five shared registers appear at 0x1B to 0x1F whatever bank is selected. Registers of the MAC and MII class return one dummy byte before their value. Set and clear commands change single bits of a register without a read-modify-write from the host.

Buffer commands stream any number of bytes through an on-chip RAM using read and write pointers that advance by themselves. A one-byte soft-reset command returns all registers to their reset state. After a reset the block accepts no writes until its clock-ready status bit comes up.

Top module: `spi_bank_regif`

## Requirements
- R1: The command byte holds the opcode in bits 7:5 and the address in bits 4:0. The opcodes are 000 register read, 001 buffer read, 010 register write, 011 buffer write, 100 bit set, 101 bit clear and 111 soft reset. Opcode 110 has no effect.
- R2: SPI mode 0, MSB first. MOSI is sampled on the SCLK rising edge, and MISO changes only after SCLK falling edges. Each SCLK phase lasts at least 4 `clk` periods.
- R3: A register read returns the value in the byte that follows the command. For MAC/MII-class registers (banks 2 and 3, addresses below `MAC_TOP`, default 0x10), the first byte is a dummy 0x00 and the value follows in the second byte.
- R4: Bits 1:0 of the control register at 0x1F select the bank used for addresses 0x00 to 0x1A. The registers at 0x1B (interrupt enable), 0x1C (interrupt flags), 0x1D (status), 0x1E (control 2) and 0x1F (control 1) are the same in every bank.
- R5: In a register write, the first data byte replaces the register. Any further bytes in the same transaction are ignored.
- R6: Bit set ORs the data byte into the register, and bit clear ANDs in its complement. All other bits keep their values.
- R7: In a buffer write, each data byte is stored at the write pointer (bank 0, address 0x02), which then advances by one and wraps modulo the depth.
- R8: A buffer read returns bytes starting at the read pointer (bank 0, address 0x00). The pointer advances by one for each data byte clocked and wraps modulo the depth.
- R9: Chip select going high during a command byte or before a full data byte aborts the command with no effect. The next transaction is decoded from a fresh command byte.
- R10: Soft reset and the reset input clear every register, both pointers and the bank field. Status bit 0 (clock ready) then reads 0 for `RDY_DLY` clk cycles and 1 afterwards. The buffer contents are kept.
- R11: While clock ready is 0, register writes, bit set, bit clear and buffer writes are ignored. Reads still work.
- R12: The status register is read-only. MISO is 0 while chip select is high and during the command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, registered |

## Verification
The bench writes and reads back every banked address of all four banks. A design with a wrong bank decode would alias the banks, and one that missed the dummy byte would return its data one byte early. Shared registers are written in one bank and read in another, and a short-decoding design would fail that check.

Both buffer pointers are driven across the top of the memory. A pointer that did not wrap, or a read path with one cycle too much or too little prefetch, would return shifted or stale bytes. Transactions are also cut short during the command byte and during the data byte, and writes are issued while clock ready is low. A decoder that kept state across chip select, or ignored the ready gate, would corrupt registers.

// File: rtl/spi_rif_pkg.sv
package spi_rif_pkg;
  typedef enum logic [2:0] {
    OP_RDREG = 3'b000,
    OP_RDBUF = 3'b001,
    OP_WRREG = 3'b010,
    OP_WRBUF = 3'b011,
    OP_BSET  = 3'b100,
    OP_BCLR  = 3'b101,
    OP_NONE  = 3'b110,
    OP_SRST  = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_RDREG, ST_WRREG, ST_RDBUF, ST_WRBUF, ST_SKIP
  } state_e;

  localparam logic [4:0] ADR_RDPTR = 5'h00;
  localparam logic [4:0] ADR_WRPTR = 5'h02;
  localparam logic [4:0] ADR_IE    = 5'h1B;
  localparam logic [4:0] ADR_IF    = 5'h1C;
  localparam logic [4:0] ADR_STAT  = 5'h1D;
  localparam logic [4:0] ADR_CTL2  = 5'h1E;
  localparam logic [4:0] ADR_CTL1  = 5'h1F;
endpackage

// File: rtl/spi_rif_frontend.sv
module spi_rif_frontend (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       cs_act,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic       miso
);
  logic [2:0] sclk_s;
  logic [1:0] cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic       rise, fall;

  // two-flop synchronisers; SCLK gets a third stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= 2'b11;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  assign cs_act = ~cs_s[1];
  assign rise   = sclk_s[1] & ~sclk_s[2];
  assign fall   = ~sclk_s[1] & sclk_s[2];

  always_ff @(posedge clk) begin
    byte_vld <= 1'b0;
    if (rst || !cs_act) begin
      bit_cnt  <= '0;
      sh       <= '0;
      miso     <= 1'b0;
      if (rst) byte_dat <= '0;
    end else begin
      if (rise) begin
        sh      <= {sh[5:0], mosi_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_dat <= {sh, mosi_s[1]};
        end
      end
      if (fall) miso <= tx_byte[~bit_cnt];
    end
  end
endmodule

// File: rtl/spi_rif_regbank.sv
module spi_rif_regbank
  import spi_rif_pkg::*;
#(
  parameter int BUF_AW  = 6,
  parameter int RDY_DLY = 32,
  parameter int MAC_TOP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [4:0]        addr,
  input  logic              we,
  input  logic [7:0]        wdat,
  input  logic              rd_inc,
  input  logic              wr_inc,
  output logic [7:0]        rdat,
  output logic              mac_cls,
  output logic [1:0]        bank,
  output logic [BUF_AW-1:0] rd_ptr,
  output logic [BUF_AW-1:0] wr_ptr,
  output logic              ready
);
  localparam int NBANK = 4;
  localparam int NBREG = 27;
  localparam int CW    = $clog2(RDY_DLY + 1);

  logic [7:0]    banked [NBANK][NBREG];
  logic [7:0]    ie_r, if_r, ctl2_r, ctl1_r;
  logic [7:0]    rp8, wp8;
  logic [CW-1:0] rdy_cnt;
  logic          is_common;

  assign bank      = ctl1_r[1:0];
  assign is_common = (addr >= ADR_IE);
  assign mac_cls   = (bank >= 2'd2) && !is_common && (int'(addr) < MAC_TOP);
  assign ready     = (rdy_cnt == CW'(RDY_DLY));

  always_comb begin
    rp8 = '0;
    wp8 = '0;
    rp8[BUF_AW-1:0] = rd_ptr;
    wp8[BUF_AW-1:0] = wr_ptr;
    if (is_common) begin
      case (addr)
        ADR_IE:   rdat = ie_r;
        ADR_IF:   rdat = if_r;
        ADR_STAT: rdat = {7'd0, ready};
        ADR_CTL2: rdat = ctl2_r;
        default:  rdat = ctl1_r;
      endcase
    end else if (bank == 2'd0 && addr == ADR_RDPTR) begin
      rdat = rp8;
    end else if (bank == 2'd0 && addr == ADR_WRPTR) begin
      rdat = wp8;
    end else begin
      rdat = banked[bank][addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int b = 0; b < NBANK; b++)
        for (int r = 0; r < NBREG; r++)
          banked[b][r] <= '0;
      ie_r    <= '0;
      if_r    <= '0;
      ctl2_r  <= '0;
      ctl1_r  <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      rdy_cnt <= '0;
    end else begin
      if (!ready) rdy_cnt <= rdy_cnt + 1'b1;
      if (we) begin
        if (is_common) begin
          case (addr)
            ADR_IE:   ie_r   <= wdat;
            ADR_IF:   if_r   <= wdat;
            ADR_CTL2: ctl2_r <= wdat;
            ADR_CTL1: ctl1_r <= wdat;
            default:  ;
          endcase
        end else if (bank == 2'd0 && addr == ADR_RDPTR) begin
          rd_ptr <= wdat[BUF_AW-1:0];
        end else if (bank == 2'd0 && addr == ADR_WRPTR) begin
          wr_ptr <= wdat[BUF_AW-1:0];
        end else begin
          banked[bank][addr] <= wdat;
        end
      end
      if (rd_inc) rd_ptr <= rd_ptr + 1'b1;
      if (wr_inc) wr_ptr <= wr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rif_bufram.sv
module spi_rif_bufram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdat,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdat
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
    rdat <= mem[raddr];
  end
endmodule

// File: rtl/spi_bank_regif.sv
module spi_bank_regif
  import spi_rif_pkg::*;
#(
  parameter int BUF_AW  = 6,
  parameter int RDY_DLY = 32,
  parameter int MAC_TOP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic              cs_act, byte_vld;
  logic [7:0]        byte_dat, tx_byte;
  state_e            state;
  opcode_e           op_q, cmd_op;
  logic [4:0]        addr_q, reg_addr;
  logic              mac_pend;
  logic [1:0]        ld_q;
  logic              reg_we, buf_we, rd_inc, wr_inc, soft_rst;
  logic [7:0]        reg_wdat, rdat, ram_q;
  logic              mac_cls, ready;
  logic [1:0]        bank;
  logic [BUF_AW-1:0] rd_ptr, wr_ptr;

  spi_rif_frontend fe_i (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .cs_act(cs_act), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .miso(spi_miso)
  );

  spi_rif_regbank #(.BUF_AW(BUF_AW), .RDY_DLY(RDY_DLY), .MAC_TOP(MAC_TOP)) rb_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .addr(reg_addr), .we(reg_we),
    .wdat(reg_wdat), .rd_inc(rd_inc), .wr_inc(wr_inc), .rdat(rdat),
    .mac_cls(mac_cls), .bank(bank), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .ready(ready)
  );

  spi_rif_bufram #(.AW(BUF_AW)) ram_i (
    .clk(clk), .we(buf_we), .waddr(wr_ptr), .wdat(byte_dat),
    .raddr(rd_ptr), .rdat(ram_q)
  );

  assign cmd_op   = opcode_e'(byte_dat[7:5]);
  assign reg_addr = (state == ST_CMD) ? byte_dat[4:0] : addr_q;

  always_comb begin
    case (op_q)
      OP_BSET: reg_wdat = rdat | byte_dat;
      OP_BCLR: reg_wdat = rdat & ~byte_dat;
      default: reg_wdat = byte_dat;
    endcase
  end

  assign reg_we   = byte_vld && (state == ST_WRREG) && ready;
  assign buf_we   = byte_vld && (state == ST_WRBUF) && ready;
  assign wr_inc   = buf_we;
  assign rd_inc   = byte_vld && (state == ST_RDBUF);
  assign soft_rst = byte_vld && (state == ST_CMD) && (cmd_op == OP_SRST);

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      state    <= ST_CMD;
      op_q     <= OP_RDREG;
      addr_q   <= '0;
      mac_pend <= 1'b0;
      ld_q     <= '0;
      tx_byte  <= '0;
    end else begin
      // RAM prefetch: pointer step, RAM read, then load into the shifter
      ld_q <= {ld_q[0], 1'b0};
      if (ld_q[1]) tx_byte <= ram_q;
      if (byte_vld) begin
        case (state)
          ST_CMD: begin
            addr_q <= byte_dat[4:0];
            op_q   <= cmd_op;
            case (cmd_op)
              OP_RDREG: begin
                state    <= ST_RDREG;
                tx_byte  <= mac_cls ? 8'h00 : rdat;
                mac_pend <= mac_cls;
              end
              OP_RDBUF: begin
                state <= ST_RDBUF;
                ld_q  <= {ld_q[0], 1'b1};
              end
              OP_WRREG, OP_BSET, OP_BCLR: state <= ST_WRREG;
              OP_WRBUF: state <= ST_WRBUF;
              default:  state <= ST_SKIP;
            endcase
          end
          ST_RDREG: begin
            tx_byte  <= mac_pend ? rdat : 8'h00;
            mac_pend <= 1'b0;
          end
          ST_WRREG: state <= ST_SKIP;
          ST_RDBUF: ld_q  <= {ld_q[0], 1'b1};
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_rif_chk.sv
module spi_rif_chk #(
  parameter int BUF_AW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              spi_miso,
  input logic              soft_rst,
  input logic              ready,
  input logic              reg_we,
  input logic              rd_inc,
  input logic              wr_inc,
  input logic [1:0]        bank,
  input logic [BUF_AW-1:0] rd_ptr,
  input logic [BUF_AW-1:0] wr_ptr
);
  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso);

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!ready && bank == 2'd0));

  // R11
  unready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !soft_rst) |=> $stable(bank));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !soft_rst) |=> $stable(bank));

  // R8
  rdptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_inc |=> rd_ptr == BUF_AW'($past(rd_ptr) + 1'b1));

  // R7
  wrptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    wr_inc |=> wr_ptr == BUF_AW'($past(wr_ptr) + 1'b1));
endmodule

bind spi_bank_regif spi_rif_chk #(.BUF_AW(BUF_AW)) chk_i (
  .clk(clk), .rst(rst), .cs_act(cs_act), .spi_miso(spi_miso),
  .soft_rst(soft_rst), .ready(ready), .reg_we(reg_we), .rd_inc(rd_inc),
  .wr_inc(wr_inc), .bank(bank), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/spi_bank_regif_tb_top.sv
module spi_bank_regif_tb_top;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int RDY   = 1500;
  localparam int MACT  = 16;
  localparam int HP    = 6;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   n_chk = 0, n_bad = 0;
  int   cur_bank = 0;
  bit   done = 0;
  logic [7:0] txb [0:79];
  logic [7:0] rxb [0:79];
  logic [7:0] v, d;

  always #4 clk = ~clk;

  spi_bank_regif #(.BUF_AW(AW), .RDY_DLY(RDY), .MAC_TOP(MACT)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic spi_run(input int nbits);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = txb[i/8][7 - (i % 8)];
      tick(HP);
      rxb[i/8][7 - (i % 8)] = miso;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
    tick(HP);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic cmd2(input logic [2:0] op, input logic [4:0] a, input logic [7:0] dat);
    txb[0] = {op, a};
    txb[1] = dat;
    spi_run(16);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] dat);
    cmd2(3'b010, a, dat);
  endtask

  task automatic set_bank(input int b);
    wr(5'h1F, 8'(b));
    cur_bank = b;
  endtask

  function automatic bit is_mac(input int b, input int a);
    return (b >= 2) && (a < MACT);
  endfunction

  task automatic rd(input logic [4:0] a, output logic [7:0] val, output logic [7:0] dum);
    bit m;
    m = is_mac(cur_bank, int'(a));
    txb[0] = {3'b000, a};
    txb[1] = 8'h00;
    txb[2] = 8'h00;
    spi_run(24);
    val = m ? rxb[2] : rxb[1];
    dum = m ? rxb[1] : 8'h00;
  endtask

  function automatic logic [7:0] pat(input int b, input int a);
    return 8'(b * 53 + a * 7 + 3);
  endfunction

  function automatic logic [7:0] gpat(input int i);
    return 8'(i * 29 + 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(10);
    rst = 1'b0;
    tick(2);
    // reset state
    check("R12 miso idle", {7'd0, miso}, 8'h00);
    rd(5'h1D, v, d);
    check("R10 ready low after reset", v, 8'h00);
    wr(5'h1B, 8'h5A);
    tick(RDY + 100);
    rd(5'h1B, v, d);
    check("R11 write ignored while not ready", v, 8'h00);
    rd(5'h1D, v, d);
    check("R10 ready high", v, 8'h01);
    rd(5'h1F, v, d);
    check("R10 ctl1 reset value", v, 8'h00);
    rd(5'h1E, v, d);
    check("R10 ctl2 reset value", v, 8'h00);

    // banked sweep (R2 serial timing, R3 dummy byte, R4 bank decode)
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int a = 3; a < 27; a++) wr(5'(a), pat(b, a));
    end
    for (int b = 0; b < 4; b++) begin
      set_bank(b);
      for (int a = 3; a < 27; a++) begin
        rd(5'(a), v, d);
        check("R2 R4 banked readback", v, pat(b, a));
        if (is_mac(b, a)) check("R3 dummy byte", d, 8'h00);
      end
    end

    // shared registers
    set_bank(1);
    wr(5'h1B, 8'hA5);
    set_bank(3);
    rd(5'h1B, v, d);
    check("R4 shared across banks", v, 8'hA5);
    rd(5'h1F, v, d);
    check("R4 bank field readback", v, 8'h03);

    // bit set / clear
    wr(5'h1E, 8'h0F);
    cmd2(3'b100, 5'h1E, 8'hF0);
    rd(5'h1E, v, d);
    check("R6 bit set", v, 8'hFF);
    cmd2(3'b101, 5'h1E, 8'h3C);
    rd(5'h1E, v, d);
    check("R6 bit clear", v, 8'hC3);
    cmd2(3'b100, 5'h05, 8'h81);
    rd(5'h05, v, d);
    check("R6 bit set on MAC-class reg", v, pat(3, 5) | 8'h81);
    check("R3 dummy on MAC-class reg", d, 8'h00);

    // extra write bytes ignored
    set_bank(1);
    txb[0] = 8'h45; txb[1] = 8'h11; txb[2] = 8'h22;
    spi_run(24);
    rd(5'h05, v, d);
    check("R5 extra bytes ignored", v, 8'h11);

    // aborted commands
    txb[0] = 8'h5F; txb[1] = 8'h02;
    spi_run(4);
    rd(5'h1F, v, d);
    check("R9 partial command byte", v, 8'h01);
    txb[0] = 8'h45; txb[1] = 8'h77;
    spi_run(13);
    rd(5'h05, v, d);
    check("R9 partial data byte", v, 8'h11);
    wr(5'h06, 8'h99);
    rd(5'h06, v, d);
    check("R9 fresh decode after abort", v, 8'h99);

    // status read-only, unused opcode
    wr(5'h1D, 8'hFE);
    rd(5'h1D, v, d);
    check("R12 status read-only", v, 8'h01);
    cmd2(3'b110, 5'h1E, 8'h55);
    rd(5'h1E, v, d);
    check("R1 opcode 110 no effect", v, 8'hC3);

    // buffer full sweep
    set_bank(0);
    wr(5'h02, 8'h00);
    txb[0] = 8'h60;
    for (int i = 0; i < DEPTH; i++) txb[1 + i] = gpat(i);
    spi_run((DEPTH + 1) * 8);
    rd(5'h02, v, d);
    check("R7 write pointer wrap", v, 8'h00);
    wr(5'h00, 8'h00);
    txb[0] = 8'h20;
    for (int i = 0; i < DEPTH; i++) txb[1 + i] = 8'h00;
    spi_run((DEPTH + 1) * 8);
    for (int i = 0; i < DEPTH; i++) check("R8 buffer stream read", rxb[1 + i], gpat(i));
    rd(5'h00, v, d);
    check("R8 read pointer wrap", v, 8'h00);

    // pointers crossing the top
    wr(5'h02, 8'(DEPTH - 3));
    txb[0] = 8'h60;
    for (int j = 0; j < 5; j++) txb[1 + j] = 8'hC0 + 8'(j);
    spi_run(6 * 8);
    rd(5'h02, v, d);
    check("R7 pointer after wrap", v, 8'h02);
    wr(5'h00, 8'(DEPTH - 4));
    txb[0] = 8'h20;
    spi_run(7 * 8);
    check("R8 byte before wrap", rxb[1], gpat(DEPTH - 4));
    for (int j = 0; j < 5; j++) check("R8 wrapped read", rxb[2 + j], 8'hC0 + 8'(j));
    rd(5'h00, v, d);
    check("R8 read pointer after wrap", v, 8'h02);

    // soft reset
    txb[0] = 8'hFF;
    spi_run(8);
    cur_bank = 0;
    rd(5'h1D, v, d);
    check("R10 ready low after soft reset", v, 8'h00);
    wr(5'h1E, 8'h33);
    txb[0] = 8'h60; txb[1] = 8'hEE;
    spi_run(16);
    cmd2(3'b100, 5'h1B, 8'hFF);
    tick(RDY + 100);
    rd(5'h1E, v, d);
    check("R11 write gated after soft reset", v, 8'h00);
    rd(5'h1B, v, d);
    check("R11 bit set gated after soft reset", v, 8'h00);
    rd(5'h1F, v, d);
    check("R10 bank cleared", v, 8'h00);
    rd(5'h02, v, d);
    check("R10 write pointer cleared", v, 8'h00);
    rd(5'h05, v, d);
    check("R10 banked reg cleared", v, 8'h00);
    txb[0] = 8'h20;
    spi_run(3 * 8);
    check("R10 R11 buffer kept", rxb[1], 8'hC3);
    check("R10 R11 buffer kept", rxb[2], 8'hC4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule